// File: doc/BRIEF.md
# Shared Segment / Key-Strobe Pin Multiplexer

This block owns sixteen output pins that serve two purposes. For most of each display frame they carry segment data for a liquid-crystal panel. For a short window at the end of the frame they carry a strobe pattern for a key matrix instead. Four key return lines are sampled only inside that strobe window. Sixteen strobes times four returns gives a matrix of up to 64 keys, with no extra pins for the keyboard.

A free-running slot counter divides every frame into `SEG_CYC` segment cycles followed by `KEY_CYC` strobe cycles. A host bus write port loads two registers. One is a strobe-pattern register. The other is a two-bit mode register, which switches the strobe phase on or off and marks the display as in use or dark. The returns are latched on the final strobe cycle. The host reads them back as a four-bit key port at a fixed read address. Waveform voltages, common-line drive, scan policy and debouncing belong to other blocks.

Top module: `segkey_mux`

## Requirements
- R1: Each frame is exactly `SEG_CYC` cycles with `keyPhase` low, followed by exactly `KEY_CYC` cycles with `keyPhase` high, and then it repeats without a gap. After reset the first frame starts in its segment phase.
- R2: When the display is on and the strobe phase is enabled, `pinOut` equals `segData` while `keyPhase` is low. While `keyPhase` is high, `pinOut` equals the active strobe pattern.
- R3: When the display is on and the strobe phase is disabled, `pinOut` follows `segData` in every cycle, including strobe-phase cycles.
- R4: When the display is marked unused, `pinOut` is all zero in every cycle, whatever the strobe setting.
- R5: A write with `wrAddr` = 0 loads the strobe-pattern register from `wrData`. A write with `wrAddr` = 1 loads the mode register from `wrData[1:0]`: bit 0 enables the strobe phase and bit 1 turns the display on. A mode write takes effect on the next cycle.
- R6: A strobe-pattern write reaches the pins only at the start of the next strobe phase, and `pinOut` holds steady through a strobe phase. A write made in the last segment cycle of a frame takes effect for the strobe phase that starts on the next cycle.
- R7: `keyIn` is captured only at the clock edge that ends the last strobe cycle, and only while the display is on and the strobe phase is enabled. A pressed key reads as 1. The captured value holds until the next capture.
- R8: With `rdAddr` = 2, `rdData` returns the captured key port. Any other read address returns zero.
- R9: Reset clears the strobe-pattern register, the key port and the mode register, so the pins are driven low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| segData | input | 16 | Segment data for the segment phase |
| keyIn | input | 4 | Key matrix return lines, 1 = pressed |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 2 | Host write address (0 strobe pattern, 1 mode) |
| wrData | input | 16 | Host write data |
| rdAddr | input | 2 | Host read address (2 key port) |
| rdData | output | 4 | Host read data |
| pinOut | output | 16 | Shared segment / strobe pins |
| keyPhase | output | 1 | High during the strobe phase of the frame |

## Verification
Two things can happen on the same clock edge: a host write to the strobe-pattern register, and the transfer of the pending pattern into the active strobe register at the boundary between the segment and strobe phases. The bench aligns to the frame and issues a write in exactly the last segment cycle. It expects the new pattern, not the older one, on the first strobe cycle. It also checks that a write made inside a strobe phase leaves the pins unchanged until the next frame.

// File: rtl/segkey_pkg.sv
package segkey_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_STROBE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_KEYPORT = 2'd2;

  typedef struct packed {
    logic keyPhase;   // current slot belongs to the strobe phase
    logic loadStrobe; // last segment cycle: move pending pattern to active
    logic wrStrobe;   // host is writing the pattern register now
    logic capture;    // last strobe cycle with scanning active
  } ctrl_strobe_t;
endpackage

// File: rtl/segkey_ctrl.sv
module segkey_ctrl
  import segkey_pkg::*;
#(
  parameter int SEG_CYC = 6,
  parameter int KEY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        modeBits,
  output ctrl_strobe_t      strobes,
  output logic              keyEn,
  output logic              dispOn
);
  localparam int FRAME = SEG_CYC + KEY_CYC;
  localparam int CW    = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [CW-1:0] LAST_SLOT = CW'(FRAME - 1);
  localparam logic [CW-1:0] LAST_SEG  = CW'(SEG_CYC - 1);
  localparam logic [CW-1:0] FIRST_KEY = CW'(SEG_CYC);

  logic [CW-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotCnt <= '0;
    end else if (slotCnt == LAST_SLOT) begin
      slotCnt <= '0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyEn  <= 1'b0;
      dispOn <= 1'b0;
    end else if (wrEn && wrAddr == ADDR_MODE) begin
      keyEn  <= modeBits[0];
      dispOn <= modeBits[1];
    end
  end

  always_comb begin
    strobes.keyPhase   = (slotCnt >= FIRST_KEY);
    strobes.loadStrobe = (slotCnt == LAST_SEG);
    strobes.wrStrobe   = wrEn && (wrAddr == ADDR_STROBE);
    strobes.capture    = (slotCnt == LAST_SLOT) && keyEn && dispOn;
  end
endmodule

// File: rtl/segkey_dp.sv
module segkey_dp
  import segkey_pkg::*;
#(
  parameter int PIN_W = 16,
  parameter int KEY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobes,
  input  logic              keyEn,
  input  logic              dispOn,
  input  logic [PIN_W-1:0]  segData,
  input  logic [PIN_W-1:0]  wrData,
  input  logic [KEY_W-1:0]  keyIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [KEY_W-1:0]  rdData,
  output logic [PIN_W-1:0]  pinOut
);
  logic [PIN_W-1:0] pendPattern;
  logic [PIN_W-1:0] livePattern;
  logic [KEY_W-1:0] keyPort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendPattern <= '0;
    end else if (strobes.wrStrobe) begin
      pendPattern <= wrData;
    end
  end

  // a write in the boundary cycle is forwarded straight to the live copy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      livePattern <= '0;
    end else if (strobes.loadStrobe) begin
      livePattern <= strobes.wrStrobe ? wrData : pendPattern;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyPort <= '0;
    end else if (strobes.capture) begin
      keyPort <= keyIn;
    end
  end

  always_comb begin
    if (!dispOn) begin
      pinOut = '0;
    end else if (strobes.keyPhase && keyEn) begin
      pinOut = livePattern;
    end else begin
      pinOut = segData;
    end
  end

  assign rdData = (rdAddr == ADDR_KEYPORT) ? keyPort : '0;
endmodule

// File: rtl/segkey_mux.sv
module segkey_mux
  import segkey_pkg::*;
#(
  parameter int PIN_W   = 16,
  parameter int KEY_W   = 4,
  parameter int SEG_CYC = 6,
  parameter int KEY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  segData,
  input  logic [KEY_W-1:0]  keyIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PIN_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [KEY_W-1:0]  rdData,
  output logic [PIN_W-1:0]  pinOut,
  output logic              keyPhase
);
  ctrl_strobe_t strobes;
  logic keyEn;
  logic dispOn;

  segkey_ctrl #(.SEG_CYC(SEG_CYC), .KEY_CYC(KEY_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .modeBits(wrData[1:0]), .strobes(strobes), .keyEn(keyEn), .dispOn(dispOn)
  );

  segkey_dp #(.PIN_W(PIN_W), .KEY_W(KEY_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .keyEn(keyEn), .dispOn(dispOn),
    .segData(segData), .wrData(wrData), .keyIn(keyIn), .rdAddr(rdAddr),
    .rdData(rdData), .pinOut(pinOut)
  );

  assign keyPhase = strobes.keyPhase;
endmodule

// File: rtl/segkey_mux_chk.sv
module segkey_mux_chk #(
  parameter int PIN_W   = 16,
  parameter int KEY_W   = 4,
  parameter int SEG_CYC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIN_W-1:0] segData,
  input logic [PIN_W-1:0] pinOut,
  input logic             keyPhase,
  input logic             keyEn,
  input logic             dispOn,
  input logic [1:0]       rdAddr,
  input logic [KEY_W-1:0] rdData
);
  localparam int RW = $clog2(SEG_CYC + 2) + 1;
  logic [RW-1:0] segRun;

  always_ff @(posedge clk) begin
    if (!rst_n) segRun <= '0;
    else if (!keyPhase) segRun <= segRun + 1'b1;
    else segRun <= '0;
  end

  AST_SEG_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (keyPhase && !$past(keyPhase)) |-> segRun == RW'(SEG_CYC)); // R1
  AST_DARK_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !dispOn |-> pinOut == '0); // R4
  AST_SEG_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (dispOn && (!keyPhase || !keyEn)) |-> pinOut == segData); // R3
  AST_STROBE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (keyPhase && $past(keyPhase) && dispOn && keyEn && $stable(dispOn) && $stable(keyEn))
      |-> $stable(pinOut)); // R6
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == 2'd2 && $past(rdAddr) == 2'd2 && !$past(keyPhase)) |-> $stable(rdData)); // R7
  AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr != 2'd2) |-> rdData == '0); // R8
endmodule

bind segkey_mux segkey_mux_chk #(.PIN_W(PIN_W), .KEY_W(KEY_W), .SEG_CYC(SEG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .segData(segData), .pinOut(pinOut), .keyPhase(keyPhase),
  .keyEn(keyEn), .dispOn(dispOn), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/segkey_mux_tb.sv
`timescale 1ns/1ps
module segkey_mux_tb;
  localparam int SEG_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] segData = '0;
  logic [3:0]  keyIn = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = 2'd2;
  logic [3:0]  rdData;
  logic [15:0] pinOut;
  logic        keyPhase;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  segkey_mux u_dut (
    .clk(clk), .rst_n(rst_n), .segData(segData), .keyIn(keyIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .pinOut(pinOut), .keyPhase(keyPhase)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] pattern;
    logic [15:0] seg;
    logic [3:0]  keys;
    logic [15:0] segExp;
    logic [15:0] keyExp;
    logic [3:0]  portExp;
  } vec_t;

  // mode: bit1 display on, bit0 strobe phase enabled
  localparam vec_t VECS [6] = '{
    '{2'd3, 16'h0001, 16'hA5A5, 4'h5, 16'hA5A5, 16'h0001, 4'h5}, // R2
    '{2'd3, 16'h8000, 16'h1234, 4'hA, 16'h1234, 16'h8000, 4'hA}, // R2
    '{2'd2, 16'h00F0, 16'hFFFF, 4'h3, 16'hFFFF, 16'hFFFF, 4'hA}, // R3
    '{2'd1, 16'h0F00, 16'h5555, 4'hC, 16'h0000, 16'h0000, 4'hA}, // R4
    '{2'd0, 16'h0F00, 16'h3333, 4'h6, 16'h0000, 16'h0000, 4'hA}, // R4
    '{2'd3, 16'h0F00, 16'h0000, 4'hF, 16'h0000, 16'h0F00, 4'hF}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic syncFrame();
    @(negedge clk);
    while (!keyPhase) @(negedge clk);
    while (keyPhase) @(negedge clk);
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #400000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 pins after reset", 32'(pinOut), 32'h0);
    check("R9 port after reset", 32'(rdData), 32'h0);
    rst_n = 1'b1;
    check("R1 starts in segment phase", 32'(keyPhase), 32'h0);

    foreach (VECS[i]) begin
      syncFrame();
      segData = VECS[i].seg;
      keyIn   = VECS[i].keys;
      wrEn = 1'b1; wrAddr = 2'd1; wrData = 16'(VECS[i].mode);
      @(negedge clk);
      wrAddr = 2'd0; wrData = VECS[i].pattern;
      @(negedge clk);
      wrEn = 1'b0;
      check($sformatf("R2/R3/R4 vec%0d segment phase", i), 32'(pinOut), 32'(VECS[i].segExp));
      while (!keyPhase) @(negedge clk);
      check($sformatf("R2/R3/R4 vec%0d strobe phase", i), 32'(pinOut), 32'(VECS[i].keyExp));
      while (keyPhase) @(negedge clk);
      check($sformatf("R7 vec%0d key port", i), 32'(rdData), 32'(VECS[i].portExp));
    end

    // R6: write inside a strobe phase must not disturb the live strobes
    syncFrame();
    while (!keyPhase) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'h1111;
    @(negedge clk);
    wrEn = 1'b0;
    check("R6 mid-slot write held off", 32'(pinOut), 32'h0F00);
    while (keyPhase) @(negedge clk);
    while (!keyPhase) @(negedge clk);
    check("R6 write shown next strobe phase", 32'(pinOut), 32'h1111);

    // R6: write landing in the last segment cycle, same edge as the transfer
    syncFrame();
    repeat (SEG_CYC - 1) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'h2222;
    @(negedge clk);
    wrEn = 1'b0;
    check("R6 boundary write forwarded", 32'({keyPhase, pinOut}), 32'h12222);

    // R7: only the last strobe cycle is sampled
    keyIn = 4'h1;
    @(negedge clk);
    keyIn = 4'h6;
    @(negedge clk);
    check("R7 capture on last strobe cycle", 32'(rdData), 32'h6);
    keyIn = 4'h9;
    repeat (3) @(negedge clk);
    check("R7 port held in segment phase", 32'(rdData), 32'h6);

    rdAddr = 2'd1;
    @(negedge clk);
    check("R8 other address reads zero", 32'(rdData), 32'h0);
    rdAddr = 2'd2;
    @(negedge clk);
    check("R8 key port address", 32'(rdData), 32'h6);

    finish();
  end
endmodule